// File: doc/BRIEF.md
# Serial Two-Latch Configuration Receiver

This block takes 24-bit control words from a three-wire serial port (a shift clock, a data line and a latch strobe) and turns them into the configuration fields of a frequency synthesizer. All three pins are asynchronous to the system clock. Each one passes through a two-flop synchroniser, and the block then looks for edges on the synchronised copies. On each synchronised rising edge of the shift clock, the data bit enters a 24-bit shift register while the strobe is low. The first bit sent ends up as the word's most significant bit.

When the strobe rises, the last two bits received act as a destination code. They route the word into one of two latches, and the two latches split the word into fields differently:

- The divider latch holds a 12-bit main count, a 5-bit swallow count and a 5-bit boost-level code.
- The reference latch holds a 16-bit reference count, a lock-indicator enable and two test bits.

A one-cycle completion pulse follows each falling edge of the strobe. The latches are cleared only by the block reset, so their contents persist through any standby period of the surrounding circuit.

There is no valid/ready stream at this edge, and therefore no back-pressure. The sender owns the pacing: every level on the three pins must last at least three system clock cycles, and a word counts as delivered when the completion pulse appears. Outputs are plain level signals that always show the latch contents.

Top module: `serial_cfg_rx`

## Requirements
- R1: Bits are taken in most-significant-first. One bit is captured per synchronised rising edge of `ser_clk_i`, and a word is 24 bits. Word bit 1 (first sent) is register bit 23, and word bit 24 (last sent) is register bit 0.
- R2: On a synchronised rising edge of `ser_le_i`, the destination code {bit 23, bit 24} picks the latch. Code 00 selects the divider latch and code 01 selects the reference latch.
- R3: In a divider word, bits 1–12 are the main count (bit 1 is its MSB), bits 13–17 are the swallow count and bits 18–22 are the boost code. Example: main 314, swallow 4 and boost 0 give a total divide of 10052.
- R4: In a reference word, bits 1–16 are the reference count (bit 1 is its MSB), bits 17–19 are ignored, bit 20 is the lock-indicator enable and bits 21–22 are the test bits.
- R5: Destination codes 10 and 11 change neither latch.
- R6: While the synchronised strobe is high, rising edges of `ser_clk_i` and changes on `ser_data_i` leave the shift register unchanged. This includes a clock edge that lands in the same synchronised cycle as the strobe's rising edge.
- R7: If more or fewer than 24 bits arrive between strobes, the latch is loaded from the last 24 bits shifted in. With fewer bits, the older register bits shift up to fill the word.
- R8: `wr_done_o` is high for exactly one system clock cycle after every synchronised falling edge of the strobe, whatever the destination code. Outside those pulses it is low.
- R9: After reset, every latch field is zero and `wr_done_o` is low. Latch fields change only on a strobe-rise load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Serial shift clock (asynchronous) |
| ser_data_i | input | 1 | Serial data (asynchronous) |
| ser_le_i | input | 1 | Latch strobe (asynchronous) |
| main_cnt_o | output | 12 | Divider latch: main count |
| swal_cnt_o | output | 5 | Divider latch: swallow count |
| boost_o | output | 5 | Divider latch: boost-level code |
| ref_cnt_o | output | 16 | Reference latch: reference count |
| lock_en_o | output | 1 | Reference latch: lock-indicator enable |
| test_o | output | 2 | Reference latch: test bits |
| wr_done_o | output | 1 | One-cycle pulse after each strobe fall |

## Verification
Two functions can meet in the same synchronised cycle: a shift-clock rising edge and the strobe's rising edge, which is both a load and a shift suppression. The bench drives `ser_clk_i` and `ser_le_i` high in the same time step, with the data line at 1. The synchroniser outputs then rise together. The scoreboard expects the latch to receive the register contents from before that edge, with no extra bit shifted in. A later bare strobe pulse shows that the register was not disturbed, both by that clock edge and by clock activity during a long strobe-high period.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
  typedef enum logic [1:0] {
    DEST_DIV  = 2'b00,
    DEST_REF  = 2'b01,
    DEST_NOP2 = 2'b10,
    DEST_NOP3 = 2'b11
  } dest_e;
endpackage

// File: rtl/sctl_sync.sv
module sctl_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/sctl_shift.sv
module sctl_shift #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              sdat_i,
  input  logic              sle_i,
  output logic [WORD_W-1:0] word_o,
  output logic              load_o,
  output logic              fall_o
);
  logic              sclk_d, le_d;
  logic [WORD_W-1:0] sr_q;
  logic              shift_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      le_d   <= 1'b0;
    end else begin
      sclk_d <= sclk_i;
      le_d   <= sle_i;
    end
  end

  assign shift_en = sclk_i && !sclk_d && !sle_i;
  assign load_o   = sle_i && !le_d;
  assign fall_o   = !sle_i && le_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sr_q <= '0;
    else if (shift_en) sr_q <= {sr_q[WORD_W-2:0], sdat_i};
  end

  assign word_o = sr_q;

  // R6
  le_blocks_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sle_i |=> $stable(sr_q));

  // R1
  shift_takes_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_i && !sclk_d && !sle_i) |=> (sr_q[0] == $past(sdat_i)));
endmodule

// File: rtl/sctl_latch.sv
module sctl_latch
  import sctl_pkg::*;
#(
  parameter int WORD_W  = 24,
  parameter int MAIN_W  = 12,
  parameter int SWAL_W  = 5,
  parameter int BOOST_W = 5,
  parameter int REF_W   = 16,
  parameter int TEST_W  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [WORD_W-1:0]  word_i,
  input  logic               load_i,
  input  logic               fall_i,
  output logic [MAIN_W-1:0]  main_o,
  output logic [SWAL_W-1:0]  swal_o,
  output logic [BOOST_W-1:0] boost_o,
  output logic [REF_W-1:0]   ref_o,
  output logic               lock_en_o,
  output logic [TEST_W-1:0]  test_o,
  output logic               done_o
);
  localparam int DEST_W  = 2;
  localparam int MAIN_LO = WORD_W - MAIN_W;
  localparam int SWAL_LO = MAIN_LO - SWAL_W;
  localparam int BST_LO  = SWAL_LO - BOOST_W;
  localparam int REF_LO  = WORD_W - REF_W;
  localparam int TEST_LO = DEST_W;
  localparam int LOCK_B  = DEST_W + TEST_W;

  dest_e dest;
  logic  we_div, we_ref;

  assign dest   = dest_e'(word_i[DEST_W-1:0]);
  assign we_div = load_i && (dest == DEST_DIV);
  assign we_ref = load_i && (dest == DEST_REF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_o  <= '0;
      swal_o  <= '0;
      boost_o <= '0;
    end else if (we_div) begin
      main_o  <= word_i[WORD_W-1:MAIN_LO];
      swal_o  <= word_i[MAIN_LO-1:SWAL_LO];
      boost_o <= word_i[SWAL_LO-1:BST_LO];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_o     <= '0;
      lock_en_o <= 1'b0;
      test_o    <= '0;
    end else if (we_ref) begin
      ref_o     <= word_i[WORD_W-1:REF_LO];
      lock_en_o <= word_i[LOCK_B];
      test_o    <= word_i[TEST_LO+TEST_W-1:TEST_LO];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_o <= 1'b0;
    else        done_o <= fall_i;
  end

  // R9
  hold_without_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> ($stable(main_o) && $stable(swal_o) && $stable(boost_o)
                 && $stable(ref_o) && $stable(lock_en_o) && $stable(test_o)));

  // R5
  ignored_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && word_i[1]) |=> ($stable(main_o) && $stable(swal_o) && $stable(boost_o)
                               && $stable(ref_o) && $stable(lock_en_o) && $stable(test_o)));

  // R2
  div_spares_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && word_i[1:0] == 2'b00) |=> ($stable(ref_o) && $stable(lock_en_o) && $stable(test_o)));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

// File: rtl/serial_cfg_rx.sv
module serial_cfg_rx (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ser_clk_i,
  input  logic        ser_data_i,
  input  logic        ser_le_i,
  output logic [11:0] main_cnt_o,
  output logic [4:0]  swal_cnt_o,
  output logic [4:0]  boost_o,
  output logic [15:0] ref_cnt_o,
  output logic        lock_en_o,
  output logic [1:0]  test_o,
  output logic        wr_done_o
);
  localparam int WORD_W  = 24;
  localparam int SYNC_N  = 2;
  localparam int PIN_N   = 3;

  logic [PIN_N-1:0]  pins_s;
  logic [WORD_W-1:0] word;
  logic              load, fall;

  sctl_sync #(.W(PIN_N), .STAGES(SYNC_N)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({ser_le_i, ser_data_i, ser_clk_i}),
    .q_o   (pins_s)
  );

  sctl_shift #(.WORD_W(WORD_W)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .sclk_i (pins_s[0]),
    .sdat_i (pins_s[1]),
    .sle_i  (pins_s[2]),
    .word_o (word),
    .load_o (load),
    .fall_o (fall)
  );

  sctl_latch #(
    .WORD_W(WORD_W), .MAIN_W(12), .SWAL_W(5), .BOOST_W(5), .REF_W(16), .TEST_W(2)
  ) u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .word_i    (word),
    .load_i    (load),
    .fall_i    (fall),
    .main_o    (main_cnt_o),
    .swal_o    (swal_cnt_o),
    .boost_o   (boost_o),
    .ref_o     (ref_cnt_o),
    .lock_en_o (lock_en_o),
    .test_o    (test_o),
    .done_o    (wr_done_o)
  );

  // R8
  done_needs_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_done_o) |-> !pins_s[2]);
endmodule

// File: tb/tb_serial_cfg_rx.sv
`timescale 1ns/1ps
module tb_serial_cfg_rx;
  typedef struct packed {
    logic [11:0] m;
    logic [4:0]  s;
    logic [4:0]  b;
    logic [15:0] r;
    logic        ld;
    logic [1:0]  t;
  } st_t;

  localparam int HALF = 4;

  logic clk = 0, rst_n = 0;
  logic sclk = 0, sdat = 0, sle = 0;
  logic [11:0] main_cnt; logic [4:0] swal_cnt, boost;
  logic [15:0] ref_cnt; logic lock_en; logic [1:0] test; logic wr_done;

  int checks = 0, errors = 0;
  st_t   cur = '0;
  logic [23:0] sr_m = '0;
  st_t   exp_q[$];
  string tag_q[$];
  logic  prev_done = 0;
  bit    done_flag = 0;

  always #5 clk = ~clk;

  serial_cfg_rx dut (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(sclk), .ser_data_i(sdat), .ser_le_i(sle),
    .main_cnt_o(main_cnt), .swal_cnt_o(swal_cnt), .boost_o(boost), .ref_cnt_o(ref_cnt),
    .lock_en_o(lock_en), .test_o(test), .wr_done_o(wr_done)
  );

  function automatic st_t observed();
    return '{m: main_cnt, s: swal_cnt, b: boost, r: ref_cnt, ld: lock_en, t: test};
  endfunction

  task automatic compare(input string tag, input st_t act, input st_t exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // model of R2/R3/R4/R5 applied at strobe rise
  function automatic void model_load();
    case (sr_m[1:0])
      2'b00: begin cur.m = sr_m[23:12]; cur.s = sr_m[11:7]; cur.b = sr_m[6:2]; end
      2'b01: begin cur.r = sr_m[23:8]; cur.ld = sr_m[4]; cur.t = sr_m[3:2]; end
      default: ;
    endcase
  endfunction

  task automatic clk_bit(input logic b);
    @(negedge clk); sdat = b;
    repeat (HALF) @(negedge clk);
    sclk = 1;
    if (!sle) sr_m = {sr_m[22:0], b};
    repeat (HALF) @(negedge clk);
    sclk = 0;
  endtask

  task automatic send(input logic [31:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) clk_bit(w[i]);
  endtask

  task automatic strobe(input string tag);
    @(negedge clk); sle = 1;
    model_load(); exp_q.push_back(cur); tag_q.push_back(tag);
    repeat (8) @(negedge clk);
    sle = 0;
    repeat (8) @(negedge clk);
  endtask

  function automatic logic [23:0] w_div(input logic [11:0] m, input logic [4:0] s, input logic [4:0] b);
    return {m, s, b, 2'b00};
  endfunction
  function automatic logic [23:0] w_ref(input logic [15:0] r, input logic ld, input logic [1:0] t);
    return {r, 3'b000, ld, t, 2'b01};
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_done) begin
        checks++;
        if (wr_done !== 1'b0) begin
          errors++;
          $display("FAIL R8 pulse width actual=%b expected=0", wr_done);
        end
      end
      if (wr_done === 1'b1 && !prev_done) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R8 unexpected pulse actual=1 expected=0");
        end else compare(tag_q.pop_front(), observed(), exp_q.pop_front());
      end
      prev_done = wr_done;
    end
  end

  initial begin
    #1_000_000;
    if (!done_flag) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    compare("R9 reset fields", observed(), '0);
    checks++;
    if (wr_done !== 1'b0) begin errors++; $display("FAIL R9 done actual=%b expected=0", wr_done); end
    rst_n = 1;
    repeat (4) @(negedge clk);

    send(w_div(12'd314, 5'd4, 5'd0), 24);            strobe("R3 ratio 10052");
    send(w_ref(16'd144, 1'b1, 2'b00), 24);           strobe("R4 ref 144 lock on");
    send(w_div(12'd4095, 5'd31, 5'b10101), 24);      strobe("R3 max fields boost");
    send(w_ref(16'hA5C3, 1'b0, 2'b10), 24);          strobe("R2 R4 ref pattern");
    send({12'hFFF, 5'h1F, 5'h1F, 2'b10}, 24);        strobe("R5 code 10 ignored");
    send({16'h1234, 6'h3F, 2'b11}, 24);              strobe("R5 code 11 ignored");
    send(w_div(12'h5A5, 5'h0A, 5'h11), 24);          strobe("R1 msb first pattern");
    send(32'h000ABCD, 20);                           strobe("R7 short word");
    send(32'hF123456C, 28);                          strobe("R7 long word");
    send(w_ref(16'h0F0F, 1'b1, 2'b01), 24);          strobe("R2 ref select");

    // R6: clocking while strobe high is ignored
    send(w_div(12'd100, 5'd7, 5'd3), 24);
    @(negedge clk); sle = 1;
    model_load(); exp_q.push_back(cur); tag_q.push_back("R6 load before noise");
    for (int k = 0; k < 5; k++) clk_bit(k[0]);
    @(negedge clk); sle = 0;
    repeat (8) @(negedge clk);
    strobe("R6 register untouched");

    // R6: clock edge and strobe rise in the same cycle
    send(w_ref(16'h0777, 1'b0, 2'b11), 24);
    @(negedge clk); sdat = 1;
    repeat (HALF) @(negedge clk);
    sclk = 1; sle = 1;
    model_load(); exp_q.push_back(cur); tag_q.push_back("R6 coincident edge");
    repeat (8) @(negedge clk);
    sclk = 0; sle = 0;
    repeat (8) @(negedge clk);
    strobe("R6 coincident no shift");

    repeat (10) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R8 missing pulses actual=%0d expected=0", exp_q.size());
    end
    done_flag = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule